// File: doc/BRIEF.md
# DMA Channel Request Selector

This block sits in front of a bank of DMA channels and decides, for each channel, whether a peripheral or software is asking that channel to move data. Every channel owns a small configuration word: a source field that names one peripheral and a signal field that names one of that peripheral's request outputs. Each peripheral presents one burst request line per signal. Some peripherals, the serial ports, also present a single-transfer request line per signal. The selector routes the chosen lines to two per-channel flags: a burst flag, asking for a full block of transfers, and a single flag, asking for exactly one transfer.

The single path is gated by a per-channel enable bit held in the same configuration word, and it is honoured only when the burst line of the same selection is idle. Software can also start any channel through a one-cycle trigger pulse. The trigger is held in a per-channel pending latch and keeps the burst flag raised until the channel engine acknowledges it. Configuration words are written one channel at a time through a simple write port. Descriptor handling, bus mastering and arbitration between channels are done elsewhere.

Top module: `dmasel_top`

## Requirements
- R1: While reset is high and on the first cycle after it, every burst and single flag is 0; reset clears every configuration word to source 0, signal 0, single disabled.
- R2: With a channel's source field at value s in 1..NUM_SRC and signal field g, its burst flag equals periph_burst bit (s-1)*4+g as sampled at the previous rising clock edge (the default build has 4 signals per peripheral).
- R3: A channel's single flag is 1 only when the selected periph_single bit was 1, the selected peripheral is single-capable (bit s-1 of SREQ_MASK; by default sources 2 and 3), the channel's single enable is 1, and the burst flag is 0.
- R4: With the single enable of a channel at 0, its single flag stays 0 for any periph_single pattern.
- R5: When the selected burst and single lines are both 1, the burst flag is 1 and the single flag is 0; the two flags of a channel are never 1 together.
- R6: A source field of 0 or above NUM_SRC gives no burst and no single request from peripheral lines, whatever those lines carry.
- R7: A pulse on sw_trig for a channel sets its pending trigger; the burst flag is 1 from the next cycle and stays 1 until the cycle after ch_ack for that channel is seen.
- R8: If sw_trig and ch_ack arrive for a channel in the same cycle, the trigger stays pending.
- R9: A configuration write changes only the channel named by cfg_ch; a cfg_ch value of NUM_CH or more changes no channel.
- R10: A configuration written at one clock edge governs peripheral lines sampled from the next edge on; lines sampled at the write edge still use the old word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | CH_W (4) | Channel written by cfg_we |
| cfg_src | input | SRC_W (4) | Source field to write; 0 selects nothing |
| cfg_sig | input | SIG_W (2) | Signal field to write |
| cfg_single_en | input | 1 | Single-request enable to write |
| sw_trig | input | NUM_CH (12) | Per-channel software trigger pulse |
| ch_ack | input | NUM_CH (12) | Per-channel acknowledge clearing a pending trigger |
| periph_burst | input | NUM_SRC*4 (24) | Burst request lines, peripheral-major |
| periph_single | input | NUM_SRC*4 (24) | Single request lines, same layout |
| ch_burst_req | output | NUM_CH (12) | Registered per-channel burst flag |
| ch_single_req | output | NUM_CH (12) | Registered per-channel single flag |

## Verification
A software trigger and a channel acknowledge can land on the same channel in the same cycle, and so can a burst and a single line of one selection. The bench provokes both, pulsing sw_trig together with ch_ack and then idling the acknowledge, and raising both peripheral lines of a single-capable selection at once. A reference model, updated per cycle from the requirements, predicts that the trigger survives and the burst flag stays up, and that the single flag stays low while the burst line is high. A random phase then mixes triggers, acknowledges, writes and line patterns so that these collisions recur with configuration writes landing on the same edges.

// File: rtl/dmasel_pkg.sv
package dmasel_pkg;
  parameter int SRC_W = 4;
  parameter int SIG_W = 2;

  typedef struct packed {
    logic [SRC_W-1:0] src;
    logic [SIG_W-1:0] sig;
    logic             sen;
  } chcfg_t;
endpackage

// File: rtl/dmasel_cfg_bank.sv
module dmasel_cfg_bank
  import dmasel_pkg::*;
#(
  parameter int NUM_CH = 12,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [CH_W-1:0] wch,
  input  chcfg_t          wdata,
  output chcfg_t          cfg [NUM_CH]
);
  // One register per channel; an out-of-range index matches none.
  for (genvar c = 0; c < NUM_CH; c++) begin : g_reg
    chcfg_t word_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        word_q <= '0;
      end else if (we && (wch == CH_W'(c))) begin
        word_q <= wdata;
      end
    end
    assign cfg[c] = word_q;
  end
endmodule

// File: rtl/dmasel_src_mux.sv
module dmasel_src_mux
  import dmasel_pkg::*;
#(
  parameter int                 NUM_SRC   = 6,
  parameter int                 NSIG      = 4,
  parameter logic [NUM_SRC-1:0] SREQ_MASK = '0,
  localparam int                NLINE     = NUM_SRC * NSIG
) (
  input  chcfg_t           cfg,
  input  logic [NLINE-1:0] burst_in,
  input  logic [NLINE-1:0] single_in,
  output logic             sel_burst,
  output logic             sel_single
);
  // Source value p+1 picks peripheral p; zero and values past NUM_SRC match nothing.
  always_comb begin
    logic [NSIG-1:0] grp_b;
    logic [NSIG-1:0] grp_s;
    sel_burst  = 1'b0;
    sel_single = 1'b0;
    grp_b      = '0;
    grp_s      = '0;
    for (int p = 0; p < NUM_SRC; p++) begin
      if (cfg.src == SRC_W'(p + 1)) begin
        grp_b      = burst_in[p*NSIG +: NSIG];
        grp_s      = single_in[p*NSIG +: NSIG];
        sel_burst  = grp_b[cfg.sig];
        sel_single = grp_s[cfg.sig] & SREQ_MASK[p] & cfg.sen;
      end
    end
  end
endmodule

// File: rtl/dmasel_swtrig.sv
module dmasel_swtrig #(
  parameter int NUM_CH = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] trig,
  input  logic [NUM_CH-1:0] ack,
  output logic [NUM_CH-1:0] pend_next
);
  logic [NUM_CH-1:0] pend_q;

  // A fresh trigger outranks an acknowledge of the same cycle.
  assign pend_next = (pend_q & ~ack) | trig;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
    end else begin
      pend_q <= pend_next;
    end
  end
endmodule

// File: rtl/dmasel_top.sv
module dmasel_top
  import dmasel_pkg::*;
#(
  parameter int                 NUM_CH    = 12,
  parameter int                 NUM_SRC   = 6,
  parameter logic [NUM_SRC-1:0] SREQ_MASK = 6'b000110,
  localparam int                NSIG      = 1 << SIG_W,
  localparam int                NLINE     = NUM_SRC * NSIG,
  localparam int                CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CH_W-1:0]   cfg_ch,
  input  logic [SRC_W-1:0]  cfg_src,
  input  logic [SIG_W-1:0]  cfg_sig,
  input  logic              cfg_single_en,
  input  logic [NUM_CH-1:0] sw_trig,
  input  logic [NUM_CH-1:0] ch_ack,
  input  logic [NLINE-1:0]  periph_burst,
  input  logic [NLINE-1:0]  periph_single,
  output logic [NUM_CH-1:0] ch_burst_req,
  output logic [NUM_CH-1:0] ch_single_req
);
  chcfg_t            wr_word;
  chcfg_t            cfg [NUM_CH];
  logic [NUM_CH-1:0] pend_next;
  logic [NUM_CH-1:0] sel_b;
  logic [NUM_CH-1:0] sel_s;
  logic [NUM_CH-1:0] breq_d;
  logic [NUM_CH-1:0] sreq_d;

  assign wr_word.src = cfg_src;
  assign wr_word.sig = cfg_sig;
  assign wr_word.sen = cfg_single_en;

  dmasel_cfg_bank #(.NUM_CH(NUM_CH)) u_bank (
    .clk   (clk),
    .rst   (rst),
    .we    (cfg_we),
    .wch   (cfg_ch),
    .wdata (wr_word),
    .cfg   (cfg)
  );

  dmasel_swtrig #(.NUM_CH(NUM_CH)) u_trig (
    .clk       (clk),
    .rst       (rst),
    .trig      (sw_trig),
    .ack       (ch_ack),
    .pend_next (pend_next)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dmasel_src_mux #(
      .NUM_SRC   (NUM_SRC),
      .NSIG      (NSIG),
      .SREQ_MASK (SREQ_MASK)
    ) u_mux (
      .cfg        (cfg[c]),
      .burst_in   (periph_burst),
      .single_in  (periph_single),
      .sel_burst  (sel_b[c]),
      .sel_single (sel_s[c])
    );
  end

  // Burst path (peripheral or software) masks the single path.
  assign breq_d = sel_b | pend_next;
  assign sreq_d = sel_s & ~breq_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      ch_burst_req  <= '0;
      ch_single_req <= '0;
    end else begin
      ch_burst_req  <= breq_d;
      ch_single_req <= sreq_d;
    end
  end
endmodule

// File: rtl/dmasel_chk.sv
module dmasel_chk
  import dmasel_pkg::*;
#(
  parameter int NUM_CH  = 12,
  parameter int NUM_SRC = 6,
  localparam int NSIG   = 1 << SIG_W,
  localparam int NLINE  = NUM_SRC * NSIG,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_we,
  input logic [CH_W-1:0]   cfg_ch,
  input logic [SRC_W-1:0]  cfg_src,
  input logic [SIG_W-1:0]  cfg_sig,
  input logic              cfg_single_en,
  input logic [NUM_CH-1:0] sw_trig,
  input logic [NUM_CH-1:0] ch_ack,
  input logic [NLINE-1:0]  periph_burst,
  input logic [NLINE-1:0]  periph_single,
  input logic [NUM_CH-1:0] ch_burst_req,
  input logic [NUM_CH-1:0] ch_single_req
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (ch_burst_req == '0 && ch_single_req == '0));

  assert_flags_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
    (ch_burst_req & ch_single_req) == '0);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_prop
    assert_trig_raises_burst_R7: assert property (@(posedge clk) disable iff (rst)
      sw_trig[c] |=> ch_burst_req[c]);

    assert_trig_beats_ack_R8: assert property (@(posedge clk) disable iff (rst)
      (sw_trig[c] && ch_ack[c]) ##1 !ch_ack[c] |=> ch_burst_req[c]);

    assert_single_not_after_trig_R3: assert property (@(posedge clk) disable iff (rst)
      ch_single_req[c] |-> !$past(sw_trig[c]));
  end
endmodule

bind dmasel_top dmasel_chk #(.NUM_CH(NUM_CH), .NUM_SRC(NUM_SRC)) u_chk (.*);

// File: tb/sim_dmasel_top.sv
module sim_dmasel_top;
  localparam int NCH   = 12;
  localparam int NSRC  = 6;
  localparam int NL    = 24;
  localparam logic [NSRC-1:0] MASK = 6'b000110;

  typedef struct {
    logic [NCH-1:0] eb;
    logic [NCH-1:0] es;
    logic           chk;
    string          tag;
  } item_t;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            cfg_we = 1'b0;
  logic [3:0]      cfg_ch = '0;
  logic [3:0]      cfg_src = '0;
  logic [1:0]      cfg_sig = '0;
  logic            cfg_single_en = 1'b0;
  logic [NCH-1:0]  sw_trig = '0;
  logic [NCH-1:0]  ch_ack = '0;
  logic [NL-1:0]   periph_burst = '0;
  logic [NL-1:0]   periph_single = '0;
  logic [NCH-1:0]  ch_burst_req;
  logic [NCH-1:0]  ch_single_req;

  int n_chk = 0;
  int n_err = 0;
  item_t q[$];

  int             m_src [NCH];
  int             m_sig [NCH];
  logic           m_sen [NCH];
  logic [NCH-1:0] m_pend = '0;

  always #4 clk = ~clk;

  dmasel_top u0 (.*);

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  // Driver: applies one cycle of stimulus and pushes the predicted outputs.
  task automatic step(input logic we, input int ch, input int src, input int sig,
                      input logic sen, input logic [NCH-1:0] trig,
                      input logic [NCH-1:0] ack, input logic [NL-1:0] b,
                      input logic [NL-1:0] s, input logic chk, input string tag);
    item_t it;
    @(negedge clk);
    cfg_we = we; cfg_ch = 4'(ch); cfg_src = 4'(src); cfg_sig = 2'(sig);
    cfg_single_en = sen; sw_trig = trig; ch_ack = ack;
    periph_burst = b; periph_single = s;
    m_pend = (m_pend & ~ack) | trig;
    for (int c = 0; c < NCH; c++) begin
      logic bb, ss;
      bb = 1'b0; ss = 1'b0;
      if (m_src[c] >= 1 && m_src[c] <= NSRC) begin
        bb = b[(m_src[c]-1)*4 + m_sig[c]];
        ss = s[(m_src[c]-1)*4 + m_sig[c]] & MASK[m_src[c]-1] & m_sen[c];
      end
      it.eb[c] = bb | m_pend[c];
      it.es[c] = ss & ~it.eb[c];
    end
    it.chk = chk;
    it.tag = tag;
    q.push_back(it);
    if (we && ch < NCH) begin
      m_src[ch] = src & 15; m_sig[ch] = sig & 3; m_sen[ch] = sen;
    end
  endtask

  task automatic wr(input int ch, input int src, input int sig, input logic sen);
    step(1'b1, ch, src, sig, sen, '0, '0, '0, '0, 1'b0, "cfg");
  endtask

  task automatic chk(input logic [NCH-1:0] trig, input logic [NCH-1:0] ack,
                     input logic [NL-1:0] b, input logic [NL-1:0] s, input string tag);
    step(1'b0, 0, 0, 0, 1'b0, trig, ack, b, s, 1'b1, tag);
  endtask

  // Monitor: compares against the queue away from the clock edge.
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      if (it.chk) begin
        n_chk++;
        if (ch_burst_req !== it.eb || ch_single_req !== it.es) begin
          n_err++;
          $display("FAIL %s: burst=%h single=%h expected burst=%h single=%h",
                   it.tag, ch_burst_req, ch_single_req, it.eb, it.es);
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    n_err++;
    n_chk++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    finish_run();
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin
      m_src[c] = 0; m_sig[c] = 0; m_sen[c] = 1'b0;
    end
    repeat (3) @(posedge clk);
    #2;
    n_chk++;
    if (ch_burst_req !== '0 || ch_single_req !== '0) begin
      n_err++;
      $display("FAIL R1: burst=%h single=%h expected 0 0", ch_burst_req, ch_single_req);
    end
    @(negedge clk);
    rst = 1'b0;

    // R1: after reset all lines high yet nothing selected.
    chk('0, '0, '1, '1, "R1");

    // R10: write and line in the same cycle; old word governs.
    step(1'b1, 0, 1, 2, 1'b0, '0, '0, 24'h000004, '0, 1'b1, "R10");
    // R2: source 1 signal 2 -> bit 2.
    chk('0, '0, 24'h000004, '0, "R2");
    chk('0, '0, 24'h00000B, '0, "R2");

    // R3 / R4 / R5 on single-capable and incapable sources.
    wr(5, 2, 1, 1'b1);
    wr(6, 2, 1, 1'b0);
    wr(7, 1, 1, 1'b1);
    chk('0, '0, '0, 24'h000022, "R3");
    chk('0, '0, '0, 24'h0000FF, "R4");
    chk('0, '0, 24'h000020, 24'h000020, "R5");
    wr(8, 3, 3, 1'b1);
    chk('0, '0, '0, 24'h000800, "R3");

    // R6: unmapped sources see nothing.
    wr(9, 0, 0, 1'b1);
    wr(10, 7, 0, 1'b1);
    wr(11, 15, 3, 1'b1);
    chk('0, '0, '1, '1, "R6");

    // R9: out-of-range channel index writes nothing; ch0 keeps its word.
    wr(13, 1, 0, 1'b1);
    wr(3, 6, 3, 1'b0);
    chk('0, '0, 24'h800004, '0, "R9");

    // R7: trigger holds until acknowledged.
    chk(12'h800, '0, '0, '0, "R7");
    chk('0, '0, '0, '0, "R7");
    chk('0, '0, '0, '0, "R7");
    chk('0, 12'h800, '0, '0, "R7");
    chk('0, '0, '0, '0, "R7");

    // R8: trigger and acknowledge together.
    chk(12'h001, 12'h001, '0, '0, "R8");
    chk('0, '0, '0, '0, "R8");
    chk('0, 12'h001, '0, '0, "R8");
    // R8/R3: trigger on a channel with a live single request.
    chk(12'h020, 12'h020, '0, 24'h000020, "R8");
    chk('0, 12'h020, '0, 24'h000020, "R3");

    // Mixed traffic: R2, R3, R5, R7, R8, R9.
    for (int i = 0; i < 400; i++) begin
      int r;
      r = $urandom % 8;
      if (r == 0) begin
        step(1'b1, $urandom % 14, $urandom % 9, $urandom % 4, 1'($urandom),
             NCH'($urandom & $urandom), NCH'($urandom),
             NL'($urandom), NL'($urandom), 1'b1, "R9");
      end else begin
        chk(NCH'($urandom & $urandom & $urandom), NCH'($urandom),
            NL'($urandom), NL'($urandom), "R2");
      end
    end

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule